// File: doc/BRIEF.md
# Drive Level Adjust Encoder

During link training a sink asks the transmitter for new drive levels by returning two adjust-request bytes, each carrying a 2-bit voltage swing and a 2-bit pre-emphasis request for two lanes. This block takes those bytes on a start strobe, picks out the levels for every lane that the current lane count enables, registers them as the PHY drive settings and pulses a per-lane update strobe toward the PHY.

In the same cycle it forms the four training-set bytes that training firmware or an AUX engine writes back to the sink. Each byte carries the applied levels together with flags that mark a lane as driven at its highest swing or highest pre-emphasis. The block then counts a settling window, set as a clock-frequency and microsecond pair (2 ms by default), and raises a one-cycle done pulse when the analog drivers may be treated as stable. Lanes that the lane count leaves out keep their previous settings and bytes.

Top module: `drive_adjust_enc`

## Requirements
- R1: While rst_ni is low and after its release, swing_o, preemph_o, ts_byte_o and phy_upd_o are all zero and done_o is low.
- R2: Lanes 0 and 1 take their levels from req_lo_i: lane 0 swing from bits [1:0] and pre-emphasis from bits [3:2], lane 1 swing from bits [5:4] and pre-emphasis from bits [7:6]; lane n sits at swing_o/preemph_o bits [2n+1:2n].
- R3: Lanes 2 and 3 take their levels from req_hi_i, lane 2 from bits [3:0] and lane 3 from bits [7:4], with the same swing-low / pre-emphasis-high split inside each nibble.
- R4: Training-set byte n sits at ts_byte_o bits [8n+7:8n]; it holds the lane's swing in bits [1:0], its pre-emphasis in bits [4:3], and zero in bits [7:6].
- R5: Bit 2 of a training-set byte is 1 exactly when that lane's swing is 3, and bit 5 is 1 exactly when its pre-emphasis is 3.
- R6: On an accepted start, lane 0 is updated when lane_cnt_i is 1 or more, lane 1 when it is 2 or more, and lanes 2 and 3 only when it equals 4.
- R7: A lane that R6 does not enable keeps its swing, pre-emphasis and training-set byte unchanged.
- R8: The cycle after an accepted start, phy_upd_o is high for exactly one cycle with bit n set for each lane updated by R6; it is zero in every other cycle.
- R9: done_o is a one-cycle pulse that appears exactly SETTLE_US x CLK_KHZ / 1000 cycles after the phy_upd_o cycle of the accepted start (even when lane_cnt_i enables no lane).
- R10: A start raised while the settling window runs is ignored: no update strobe, no level change, no shift of done_o. A start raised in the cycle where done_o is high is accepted.
- R11: swing_o, preemph_o and ts_byte_o change only in a cycle where phy_upd_o is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Apply the current request bytes |
| lane_cnt_i | input | 3 | Active lane count (1, 2 or 4) |
| req_lo_i | input | 8 | Adjust request for lanes 0 and 1 |
| req_hi_i | input | 8 | Adjust request for lanes 2 and 3 |
| swing_o | output | 8 | Per-lane swing level, 2 bits per lane |
| preemph_o | output | 8 | Per-lane pre-emphasis level, 2 bits per lane |
| ts_byte_o | output | 32 | Per-lane training-set bytes, 8 bits per lane |
| phy_upd_o | output | 4 | Per-lane PHY update strobe |
| done_o | output | 1 | Settling window finished (one-cycle pulse) |

## Verification
The end of one settling window and the acceptance of the next request can fall in the same cycle: done_o is high and start_i is raised with new bytes. The bench provokes this by driving start in the very cycle it sees done_o, and judges it by requiring the update strobe and new levels on the next cycle and a fresh done_o a full window later. It also raises start in the middle of a window and requires no strobe, unchanged levels and an undisturbed done_o position.

// File: rtl/dae_pkg.sv
package dae_pkg;
  localparam int LANES    = 4;
  localparam int LVL_W    = 2;
  localparam int TS_W     = 8;
  localparam int REQ_N    = LANES / 2;
  localparam logic [LVL_W-1:0] LVL_MAX = '1;

  typedef struct packed {
    logic [LVL_W-1:0] pre;
    logic [LVL_W-1:0] swing;
  } lvl_t;

  // training-set byte: [1:0] swing, [2] swing max, [4:3] pre, [5] pre max
  function automatic logic [TS_W-1:0] ts_pack(lvl_t l);
    logic [TS_W-1:0] b;
    b      = '0;
    b[1:0] = l.swing;
    b[2]   = (l.swing == LVL_MAX);
    b[4:3] = l.pre;
    b[5]   = (l.pre == LVL_MAX);
    return b;
  endfunction
endpackage

// File: rtl/dae_lane_mask.sv
module dae_lane_mask
  import dae_pkg::*;
#(
  parameter int N_LANES = LANES
) (
  input  logic [2:0]         lane_cnt_i,
  output logic [N_LANES-1:0] en_o
);
  for (genvar l = 0; l < N_LANES; l++) begin : g_en
    if (l < 2) begin : g_low
      assign en_o[l] = (int'(lane_cnt_i) >= l + 1);
    end else begin : g_full
      // upper lanes only run in full-width mode
      assign en_o[l] = (int'(lane_cnt_i) == N_LANES);
    end
  end
endmodule

// File: rtl/dae_lane_field.sv
module dae_lane_field
  import dae_pkg::*;
#(
  parameter bit UPPER = 1'b0
) (
  input  logic [7:0]      req_i,
  output lvl_t            lvl_o,
  output logic [TS_W-1:0] ts_o
);
  logic [3:0] nib;

  if (UPPER) begin : g_hi
    assign nib = req_i[7:4];
  end else begin : g_lo
    assign nib = req_i[3:0];
  end

  assign lvl_o.swing = nib[1:0];
  assign lvl_o.pre   = nib[3:2];
  assign ts_o        = ts_pack(lvl_o);
endmodule

// File: rtl/dae_settle_timer.sv
module dae_settle_timer #(
  parameter int CYCLES = 500000,
  localparam int CW    = $clog2(CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic busy_o,
  output logic done_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (load_i && !busy_o) begin
        cnt_q  <= CW'(CYCLES - 1);
        busy_o <= 1'b1;
      end else if (busy_o) begin
        if (cnt_q == '0) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/drive_adjust_enc.sv
module drive_adjust_enc
  import dae_pkg::*;
#(
  parameter int CLK_KHZ   = 250000,
  parameter int SETTLE_US = 2000,
  localparam int SETTLE_CYC = (CLK_KHZ * SETTLE_US) / 1000
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [2:0]            lane_cnt_i,
  input  logic [7:0]            req_lo_i,
  input  logic [7:0]            req_hi_i,
  output logic [LANES*LVL_W-1:0] swing_o,
  output logic [LANES*LVL_W-1:0] preemph_o,
  output logic [LANES*TS_W-1:0]  ts_byte_o,
  output logic [LANES-1:0]       phy_upd_o,
  output logic                   done_o
);
  logic             busy;
  logic             accept;
  logic [LANES-1:0] lane_en;
  logic [7:0]       req_b [REQ_N];
  lvl_t             lvl_n [LANES];
  logic [TS_W-1:0]  ts_n  [LANES];

  assign req_b[0] = req_lo_i;
  assign req_b[1] = req_hi_i;
  assign accept   = start_i && !busy;

  dae_lane_mask #(.N_LANES(LANES)) u_mask (
    .lane_cnt_i (lane_cnt_i),
    .en_o       (lane_en)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    dae_lane_field #(.UPPER(bit'(l % 2))) u_field (
      .req_i (req_b[l/2]),
      .lvl_o (lvl_n[l]),
      .ts_o  (ts_n[l])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        swing_o[l*LVL_W +: LVL_W]   <= '0;
        preemph_o[l*LVL_W +: LVL_W] <= '0;
        ts_byte_o[l*TS_W +: TS_W]   <= '0;
      end else if (accept && lane_en[l]) begin
        swing_o[l*LVL_W +: LVL_W]   <= lvl_n[l].swing;
        preemph_o[l*LVL_W +: LVL_W] <= lvl_n[l].pre;
        ts_byte_o[l*TS_W +: TS_W]   <= ts_n[l];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phy_upd_o <= '0;
    else         phy_upd_o <= accept ? lane_en : '0;
  end

  dae_settle_timer #(.CYCLES(SETTLE_CYC)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .busy_o (busy),
    .done_o (done_o)
  );
endmodule

// File: rtl/dae_chk.sv
module dae_chk
  import dae_pkg::*;
#(
  parameter int CLK_KHZ   = 250000,
  parameter int SETTLE_US = 2000,
  localparam int SCYC = (CLK_KHZ * SETTLE_US) / 1000,
  localparam int KW   = $clog2(SCYC + 2)
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    accept_i,
  input logic [2:0]              lane_cnt_i,
  input logic [LANES*LVL_W-1:0]  swing_o,
  input logic [LANES*LVL_W-1:0]  preemph_o,
  input logic [LANES*TS_W-1:0]   ts_byte_o,
  input logic [LANES-1:0]        phy_upd_o,
  input logic                    done_o
);
  logic [KW-1:0] since_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  since_q <= KW'(SCYC + 1);
    else if (accept_i)            since_q <= '0;
    else if (since_q != KW'(SCYC + 1)) since_q <= since_q + 1'b1;
  end

  a_r1_idle_after_reset: assert property (@(posedge clk_i) $rose(rst_ni) |-> !done_o && phy_upd_o == '0);

  a_r6_legal_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_upd_o == 4'b0000 || phy_upd_o == 4'b0001 || phy_upd_o == 4'b0011 || phy_upd_o == 4'b1111);

  a_r8_mask_follows_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |=> phy_upd_o == {$past(lane_cnt_i) == 3'd4, $past(lane_cnt_i) == 3'd4,
                               $past(lane_cnt_i) >= 3'd2, $past(lane_cnt_i) >= 3'd1});

  a_r8_no_spurious_upd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phy_upd_o != '0) |-> $past(accept_i));

  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_done_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> since_q == KW'(SCYC));

  a_r11_hold_levels: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phy_upd_o == '0) |-> $stable(swing_o) && $stable(preemph_o) && $stable(ts_byte_o));

  for (genvar l = 0; l < LANES; l++) begin : g_ts
    a_r5_max_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ts_byte_o[l*TS_W+2] == (swing_o[l*LVL_W +: LVL_W] == 2'd3) &&
      ts_byte_o[l*TS_W+5] == (preemph_o[l*LVL_W +: LVL_W] == 2'd3));
    a_r4_fields_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ts_byte_o[l*TS_W +: 2] == swing_o[l*LVL_W +: LVL_W] &&
      ts_byte_o[l*TS_W+3 +: 2] == preemph_o[l*LVL_W +: LVL_W] &&
      ts_byte_o[l*TS_W+6 +: 2] == 2'b00);
  end
endmodule

bind drive_adjust_enc dae_chk #(.CLK_KHZ(CLK_KHZ), .SETTLE_US(SETTLE_US)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .accept_i   (accept),
  .lane_cnt_i (lane_cnt_i),
  .swing_o    (swing_o),
  .preemph_o  (preemph_o),
  .ts_byte_o  (ts_byte_o),
  .phy_upd_o  (phy_upd_o),
  .done_o     (done_o)
);

// File: tb/drive_adjust_enc_test.sv
module drive_adjust_enc_test;
  localparam int CLK_KHZ   = 10;
  localparam int SETTLE_US = 2000;
  localparam int S         = CLK_KHZ * SETTLE_US / 1000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  lane_cnt_i = '0;
  logic [7:0]  req_lo_i = '0;
  logic [7:0]  req_hi_i = '0;
  logic [7:0]  swing_o, preemph_o;
  logic [31:0] ts_byte_o;
  logic [3:0]  phy_upd_o;
  logic        done_o;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  logic [1:0] e_sw [4];
  logic [1:0] e_pe [4];
  logic [7:0] e_ts [4];
  logic [3:0] e_upd;

  always #2 clk = ~clk;

  drive_adjust_enc #(.CLK_KHZ(CLK_KHZ), .SETTLE_US(SETTLE_US)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .lane_cnt_i(lane_cnt_i),
    .req_lo_i(req_lo_i), .req_hi_i(req_hi_i), .swing_o(swing_o),
    .preemph_o(preemph_o), .ts_byte_o(ts_byte_o), .phy_upd_o(phy_upd_o),
    .done_o(done_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // expected model from R2..R7
  task automatic model(logic [7:0] lo, logic [7:0] hi, logic [2:0] cnt);
    for (int l = 0; l < 4; l++) begin
      bit en;
      logic [7:0] b;
      logic [3:0] nib;
      en  = (l == 0) ? (cnt >= 1) : (l == 1) ? (cnt >= 2) : (cnt == 4);
      b   = (l < 2) ? lo : hi;
      nib = 4'((b >> (4 * (l % 2))) & 8'hF);
      e_upd[l] = en;
      if (en) begin
        e_sw[l] = nib[1:0];
        e_pe[l] = nib[3:2];
        e_ts[l] = 8'(e_sw[l]) + 8'((e_sw[l] == 2'd3) ? 4 : 0)
                + 8'(e_pe[l]) * 8 + 8'((e_pe[l] == 2'd3) ? 32 : 0);
      end
    end
  endtask

  task automatic chk_levels(string tag_lo, string tag_hi, string tag_ts);
    chk(tag_lo, 32'(swing_o[3:0]),   32'({e_sw[1], e_sw[0]}));
    chk(tag_lo, 32'(preemph_o[3:0]), 32'({e_pe[1], e_pe[0]}));
    chk(tag_hi, 32'(swing_o[7:4]),   32'({e_sw[3], e_sw[2]}));
    chk(tag_hi, 32'(preemph_o[7:4]), 32'({e_pe[3], e_pe[2]}));
    chk(tag_ts, ts_byte_o, {e_ts[3], e_ts[2], e_ts[1], e_ts[0]});
  endtask

  // one request; if now, start is driven in the current negedge slot
  task automatic op(logic [7:0] lo, logic [7:0] hi, logic [2:0] cnt, bit now, bit intrude);
    if (!now) @(negedge clk);
    start_i = 1'b1; req_lo_i = lo; req_hi_i = hi; lane_cnt_i = cnt;
    @(negedge clk);
    start_i = 1'b0;
    model(lo, hi, cnt);
    chk("R8 R6 upd mask", 32'(phy_upd_o), 32'(e_upd));
    chk_levels("R2 R7 lanes0-1", "R3 R7 lanes2-3", "R4 R5 ts bytes");
    for (int i = 1; i < S; i++) begin
      @(negedge clk);
      if (done_o !== 1'b0 || phy_upd_o !== 4'b0) chk("R9 R8 early", {27'd0, phy_upd_o, done_o}, 32'd0);
      if (intrude && i == 5) begin
        start_i = 1'b1; req_lo_i = ~lo; req_hi_i = ~hi; lane_cnt_i = 3'd4;
      end
      if (intrude && i == 6) begin
        start_i = 1'b0;
        chk("R10 ignored start upd", 32'(phy_upd_o), 32'd0);
        chk_levels("R10 held", "R10 held", "R10 held ts");
      end
    end
    @(negedge clk);
    chk("R9 done timing", 32'(done_o), 32'd1);
    chk("R11 levels held", {swing_o, preemph_o, 16'd0}, {e_sw[3], e_sw[2], e_sw[1], e_sw[0],
                                                         e_pe[3], e_pe[2], e_pe[1], e_pe[0], 16'd0});
  endtask

  initial begin
    for (int l = 0; l < 4; l++) begin e_sw[l] = '0; e_pe[l] = '0; e_ts[l] = '0; end
    repeat (3) @(negedge clk);
    chk("R1 reset levels", {swing_o, preemph_o, 16'd0}, 32'd0);
    chk("R1 reset ts", ts_byte_o, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 after release", {27'd0, phy_upd_o, done_o}, 32'd0);
    chk("R1 ts after release", ts_byte_o, 32'd0);

    // full-width sweep over every request byte value
    for (int v = 0; v < 256; v++) op(8'(v), 8'(255 - v), 3'd4, 1'b0, 1'b0);

    // lane counts 0..7 with varying patterns: retention of inactive lanes
    for (int k = 0; k < 48; k++) op(8'(k * 37 + 11), 8'(k * 91 + 5), 3'(k % 8), 1'b0, 1'b0);

    // mid-window start is ignored
    op(8'h3C, 8'hC3, 3'd2, 1'b0, 1'b1);
    op(8'hFF, 8'h00, 3'd1, 1'b0, 1'b1);

    // start in the done cycle is accepted (done and accept overlap)
    op(8'h12, 8'h34, 3'd4, 1'b0, 1'b0);
    op(8'hAB, 8'hCD, 3'd2, 1'b1, 1'b0);
    op(8'hF0, 8'h0F, 3'd4, 1'b1, 1'b0);
    @(negedge clk);
    chk("R9 single pulse", 32'(done_o), 32'd0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule